// File: doc/BRIEF.md
# Reduced-Blanking Raster Timing Generator

This block produces the pixel-clock raster timing for a digital video link whose blanking intervals are much shorter than those of analog-era modes. It steps a horizontal pixel counter and a vertical line counter. From these it derives a data-enable flag, the pixel coordinate inside the visible area, horizontal and vertical sync strobes, and two pulses that a framebuffer fetch engine uses to pace itself: one at the top of each frame and one at the start of each visible line.

The active width, active height, the two blanking lengths, and where each sync pulse sits inside its blanking interval are all loaded at run time. A write is checked as it arrives. An accepted write goes into a shadow bank, and the counters only pick it up when a new frame begins: either when `run` rises, or when the last pixel of the last line wraps around. A frame that is already under way never sees a change.

The default mode is 960 by 540 visible pixels, with 16 pixel periods of horizontal blanking and 8 lines of vertical blanking. The vertical sync takes the first of those blanking lines, so the vertical front porch is zero. The link bit rate follows from refresh × total lines × total pixels × 10. For the default totals at 50 Hz this is 50 × 548 × 976 × 10, roughly 267.4 MHz. Some sinks need nine or more lines after the sync, so the vertical blanking length and the sync offset are both adjustable.

Top module: `rb_video_timing`

## Requirements
- R1: After reset the block is idle, with every output low. Once `run` is raised without any configuration write, each line lasts 976 clocks and `de` is high for the first 960 of them. Hsync is high at pixel positions 962 to 969.
- R2: A configuration write is rejected when any of these holds: the active width is zero or not a multiple of 8; the active height is zero; a sync length is zero; offset plus length of a sync exceeds its blanking length. A rejected write pulses `cfg_reject` in the cycle after the write and leaves the stored configuration unchanged.
- R3: `de` is high exactly when the pixel position is below the active width and the line number is below the active height.
- R4: `hsync` is high, on every line, for pixel positions active-width + hsync-offset up to, but not including, that value + hsync-length.
- R5: `vsync` is high for whole lines from active-height + vsync-offset for vsync-length lines. With offset 0 it starts on the first blanking line, so the front porch is zero.
- R6: During `de`, `px_x`/`px_y` give the pixel position and line number. Both are zero when `de` is low.
- R7: `sof` is high for one clock at pixel 0 of line 0. `sol` is high at pixel 0 of every visible line.
- R8: A configuration accepted while the raster runs has no effect until the first pixel of the next frame. From that pixel on it applies.
- R9: With `run` low, the counters return to pixel 0 of line 0 on the next clock and every output stays low. When `run` rises, the frame starts at pixel 0 of line 0 with the most recently accepted configuration.
- R10: A line lasts active width + horizontal blanking clocks. A frame lasts active height + vertical blanking lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Raster runs while high; idle and cleared while low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_h_active | input | HW | Visible pixels per line (multiple of 8) |
| cfg_h_blank | input | HW | Blanking pixel periods per line |
| cfg_hs_off | input | HW | Hsync start, counted from the end of the visible area |
| cfg_hs_len | input | HW | Hsync length in pixels |
| cfg_v_active | input | VW | Visible lines per frame |
| cfg_v_blank | input | VW | Blanking lines per frame, sync included |
| cfg_vs_off | input | VW | Vsync start line, counted from the end of the visible area |
| cfg_vs_len | input | VW | Vsync length in lines |
| cfg_reject | output | 1 | One-clock pulse after a refused write |
| de | output | 1 | Data enable (visible pixel) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| sof | output | 1 | Start-of-frame pulse |
| sol | output | 1 | Start-of-visible-line pulse |
| px_x | output | HW | Pixel position within the visible line |
| px_y | output | VW | Line number within the visible frame |

## Verification
Every raster output is decoded directly from the counter registers. It therefore reflects the position reached at the most recent rising edge, and the first position after `run` rises is visible one clock after the edge that samples it. `cfg_reject` appears one clock after the edge that samples the write. A shadowed configuration first shows at the position after the wrap edge. The bench drives inputs just after each falling edge and compares every output at the next falling edge. It uses a cycle-stepped model that advances its own position and configuration banks by the same rules, and sweeps each small configuration over whole frames, including a reload in mid-frame.

// File: rtl/rb_video_timing.sv
module rb_video_timing #(
  parameter int HW         = 12,
  parameter int VW         = 12,
  parameter int DEF_H_ACT  = 960,
  parameter int DEF_H_BLK  = 16,
  parameter int DEF_HS_OFF = 2,
  parameter int DEF_HS_LEN = 8,
  parameter int DEF_V_ACT  = 540,
  parameter int DEF_V_BLK  = 8,
  parameter int DEF_VS_OFF = 0,
  parameter int DEF_VS_LEN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cfg_we,
  input  logic [HW-1:0] cfg_h_active,
  input  logic [HW-1:0] cfg_h_blank,
  input  logic [HW-1:0] cfg_hs_off,
  input  logic [HW-1:0] cfg_hs_len,
  input  logic [VW-1:0] cfg_v_active,
  input  logic [VW-1:0] cfg_v_blank,
  input  logic [VW-1:0] cfg_vs_off,
  input  logic [VW-1:0] cfg_vs_len,
  output logic          cfg_reject,
  output logic          de,
  output logic          hsync,
  output logic          vsync,
  output logic          sof,
  output logic          sol,
  output logic [HW-1:0] px_x,
  output logic [VW-1:0] px_y
);

  localparam int HTW = HW + 1;
  localparam int VTW = VW + 1;
  localparam int CW  = 4 * HW + 4 * VW;
  localparam logic [CW-1:0] DEF_BUS = {
    HW'(DEF_H_ACT), HW'(DEF_H_BLK), HW'(DEF_HS_OFF), HW'(DEF_HS_LEN),
    VW'(DEF_V_ACT), VW'(DEF_V_BLK), VW'(DEF_VS_OFF), VW'(DEF_VS_LEN)};

  logic [CW-1:0]  shadow, work;
  logic [HW-1:0]  w_h_act, w_h_blk, w_hs_off, w_hs_len;
  logic [VW-1:0]  w_v_act, w_v_blk, w_vs_off, w_vs_len;
  logic [HTW-1:0] hcnt, h_act_x, h_tot, hs_a, hs_b;
  logic [VTW-1:0] vcnt, v_act_x, v_tot, vs_a, vs_b;
  logic           running, cfg_ok, h_last, v_last, h_in, v_in;

  assign {w_h_act, w_h_blk, w_hs_off, w_hs_len,
          w_v_act, w_v_blk, w_vs_off, w_vs_len} = work;

  assign cfg_ok = (cfg_h_active[2:0] == 3'd0) && (cfg_h_active != '0) &&
                  (cfg_v_active != '0) && (cfg_hs_len != '0) && (cfg_vs_len != '0) &&
                  ({1'b0, cfg_hs_off} + {1'b0, cfg_hs_len} <= {1'b0, cfg_h_blank}) &&
                  ({1'b0, cfg_vs_off} + {1'b0, cfg_vs_len} <= {1'b0, cfg_v_blank});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow     <= DEF_BUS;
      cfg_reject <= 1'b0;
    end else begin
      cfg_reject <= cfg_we && !cfg_ok;
      if (cfg_we && cfg_ok)
        shadow <= {cfg_h_active, cfg_h_blank, cfg_hs_off, cfg_hs_len,
                   cfg_v_active, cfg_v_blank, cfg_vs_off, cfg_vs_len};
    end
  end

  assign h_act_x = {1'b0, w_h_act};
  assign h_tot   = h_act_x + {1'b0, w_h_blk};
  assign hs_a    = h_act_x + {1'b0, w_hs_off};
  assign hs_b    = hs_a + {1'b0, w_hs_len};
  assign v_act_x = {1'b0, w_v_act};
  assign v_tot   = v_act_x + {1'b0, w_v_blk};
  assign vs_a    = v_act_x + {1'b0, w_vs_off};
  assign vs_b    = vs_a + {1'b0, w_vs_len};
  assign h_last  = (hcnt == h_tot - 1'b1);
  assign v_last  = (vcnt == v_tot - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
      work    <= DEF_BUS;
    end else if (!run) begin
      running <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else if (!running) begin
      running <= 1'b1;
      hcnt    <= '0;
      vcnt    <= '0;
      work    <= shadow;
    end else if (h_last) begin
      hcnt <= '0;
      if (v_last) begin
        vcnt <= '0;
        work <= shadow;
      end else begin
        vcnt <= vcnt + 1'b1;
      end
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign h_in  = hcnt < h_act_x;
  assign v_in  = vcnt < v_act_x;
  assign de    = running && h_in && v_in;
  assign hsync = running && (hcnt >= hs_a) && (hcnt < hs_b);
  assign vsync = running && (vcnt >= vs_a) && (vcnt < vs_b);
  assign sof   = running && (hcnt == '0) && (vcnt == '0);
  assign sol   = running && (hcnt == '0) && v_in;
  assign px_x  = de ? hcnt[HW-1:0] : '0;
  assign px_y  = de ? vcnt[VW-1:0] : '0;

  assert_bad_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_h_active[2:0] != 3'd0) |=> cfg_reject);

  assert_vsync_line_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> (hcnt == '0));

  assert_sof_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !sof);

  assert_sol_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sol |-> de);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!de && !hsync && !vsync && !sof && !sol));

  assert_line_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (hcnt < h_tot) && (vcnt < v_tot));

endmodule

// File: tb/rb_video_timing_tb.sv
module rb_video_timing_tb_top;
  localparam int HW = 12;
  localparam int VW = 12;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, cfg_we = 1'b0;
  logic [HW-1:0] cfg_h_active = '0, cfg_h_blank = '0, cfg_hs_off = '0, cfg_hs_len = '0;
  logic [VW-1:0] cfg_v_active = '0, cfg_v_blank = '0, cfg_vs_off = '0, cfg_vs_len = '0;
  logic cfg_reject, de, hsync, vsync, sof, sol;
  logic [HW-1:0] px_x;
  logic [VW-1:0] px_y;

  always #5 clk = ~clk;

  rb_video_timing dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we),
    .cfg_h_active(cfg_h_active), .cfg_h_blank(cfg_h_blank),
    .cfg_hs_off(cfg_hs_off), .cfg_hs_len(cfg_hs_len),
    .cfg_v_active(cfg_v_active), .cfg_v_blank(cfg_v_blank),
    .cfg_vs_off(cfg_vs_off), .cfg_vs_len(cfg_vs_len),
    .cfg_reject(cfg_reject), .de(de), .hsync(hsync), .vsync(vsync),
    .sof(sof), .sol(sol), .px_x(px_x), .px_y(px_y));

  int checks = 0, fails = 0;
  int cur[8];
  int shd[8];
  int mh = 0, mv = 0;
  bit m_run = 0, m_rej = 0, done = 0;
  string phase = "R1 reset";

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d (h=%0d v=%0d)", tag, phase, act, exp, mh, mv);
    end
  endtask

  task automatic compare();
    bit e_de = 0, e_hs = 0, e_vs = 0, e_sof = 0, e_sol = 0;
    if (m_run) begin
      e_de  = (mh < cur[0]) && (mv < cur[4]);
      e_hs  = (mh >= cur[0] + cur[2]) && (mh < cur[0] + cur[2] + cur[3]);
      e_vs  = (mv >= cur[4] + cur[6]) && (mv < cur[4] + cur[6] + cur[7]);
      e_sof = (mh == 0) && (mv == 0);
      e_sol = (mh == 0) && (mv < cur[4]);
    end
    check("R2 cfg_reject", int'(cfg_reject), int'(m_rej));
    check("R3 de", int'(de), int'(e_de));
    check("R4 hsync", int'(hsync), int'(e_hs));
    check("R5 vsync", int'(vsync), int'(e_vs));
    check("R7 sof", int'(sof), int'(e_sof));
    check("R7 sol", int'(sol), int'(e_sol));
    check("R6 px_x", int'(px_x), e_de ? mh : 0);
    check("R6 px_y", int'(px_y), e_de ? mv : 0);
  endtask

  task automatic cyc(bit r, bit we, int ha = 0, int hb = 0, int hso = 0, int hsl = 0,
                     int va = 0, int vb = 0, int vso = 0, int vsl = 0);
    bit ok;
    @(negedge clk);
    compare();
    run = r; cfg_we = we;
    cfg_h_active = HW'(ha); cfg_h_blank = HW'(hb); cfg_hs_off = HW'(hso); cfg_hs_len = HW'(hsl);
    cfg_v_active = VW'(va); cfg_v_blank = VW'(vb); cfg_vs_off = VW'(vso); cfg_vs_len = VW'(vsl);
    ok = we && (ha % 8 == 0) && ha != 0 && va != 0 && hsl != 0 && vsl != 0 &&
         (hso + hsl <= hb) && (vso + vsl <= vb);
    if (!r) begin
      m_run = 0; mh = 0; mv = 0;
    end else if (!m_run) begin
      m_run = 1; mh = 0; mv = 0; cur = shd;
    end else if (mh == cur[0] + cur[1] - 1) begin
      mh = 0;
      if (mv == cur[4] + cur[5] - 1) begin mv = 0; cur = shd; end
      else mv++;
    end else mh++;
    if (ok) shd = '{ha, hb, hso, hsl, va, vb, vso, vsl};
    m_rej = we && !ok;
  endtask

  task automatic idle_cycles(bit r, int n);
    for (int i = 0; i < n; i++) cyc(r, 1'b0);
  endtask

  initial begin
    shd = '{960, 16, 2, 8, 540, 8, 0, 1};
    cur = shd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset cfg_reject", int'(cfg_reject), 0);
    check("R1 reset de", int'(de), 0);
    check("R1 reset vsync", int'(vsync), 0);
    rst_n = 1'b1;
    idle_cycles(1'b0, 3);

    phase = "R1 default lines R10";
    idle_cycles(1'b1, 3 * 976 + 12);
    phase = "R9 stop";
    idle_cycles(1'b0, 4);

    phase = "R2 reject width";
    cyc(1'b0, 1'b1, 20, 6, 1, 2, 4, 3, 0, 1);
    phase = "R2 reject zero width";
    cyc(1'b0, 1'b1, 0, 6, 1, 2, 4, 3, 0, 1);
    phase = "R2 reject vsync window";
    cyc(1'b0, 1'b1, 16, 6, 1, 2, 4, 3, 3, 1);
    phase = "R2 reject hsync window";
    cyc(1'b0, 1'b1, 16, 6, 5, 2, 4, 3, 0, 1);
    phase = "R2 accept small A";
    cyc(1'b0, 1'b1, 16, 6, 1, 2, 4, 3, 0, 1);
    idle_cycles(1'b0, 2);

    phase = "R9 start A R10 R5 zero front porch";
    idle_cycles(1'b1, 2 * 22 * 7 + 30);
    phase = "R8 mid-frame reload to B";
    cyc(1'b1, 1'b1, 24, 10, 3, 4, 3, 12, 2, 2);
    idle_cycles(1'b1, 22 * 7 + 3 * 34 * 15);
    phase = "R2 reject while running";
    cyc(1'b1, 1'b1, 12, 10, 3, 4, 3, 12, 2, 2);
    idle_cycles(1'b1, 40);
    phase = "R9 stop mid-frame";
    idle_cycles(1'b0, 3);

    phase = "R2 accept small C";
    cyc(1'b0, 1'b1, 8, 2, 0, 2, 2, 10, 0, 1);
    phase = "R9 restart C";
    idle_cycles(1'b1, 3 * 10 * 12 + 5);
    idle_cycles(1'b0, 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule